// File: doc/BRIEF.md
# Secure Configuration Access Controller

This block sits beside a device configuration port and decides, cycle by cycle, which configuration-side requests may proceed. Frame writes, plain command words, readback requests and key-memory accesses all pass through it. It answers each one with a grant or deny pulse one cycle later. It also drives a wipe pulse that clears keys and configuration, a startup enable, and a level telling user logic whether the decryptor may be borrowed.

Once a load marked as encrypted starts, the controller locks the port down. Only one complete, ordered load from frame zero to the last frame is accepted. Readback and the decryptor stay closed. The design starts only after an external integrity checker reports a pass. Any touch of the key memory is treated as tampering: it wipes everything and sets a sticky flag. Unencrypted loads keep the permissive policy, with partial writes, any frame order, readback and reconfiguration all allowed. The cipher, the integrity computation and the configuration memory are outside this block.

States: UNCFG (unconfigured), LOAD_ENC, LOAD_PLN, CHECK, RUN_ENC, RUN_PLN and CLEAR. The transitions are:

- UNCFG to LOAD_ENC on an encrypted frame at address 0.
- UNCFG to LOAD_PLN on any plain frame.
- Either load state to CHECK on a frame at the last address. UNCFG goes straight to CHECK when the opening frame is the last one.
- LOAD_ENC to CLEAR on an out-of-order frame.
- CHECK to RUN_ENC or RUN_PLN on a pass.
- CHECK to CLEAR on a fail.
- Any state to CLEAR on a key access or a full-clear command.
- CLEAR to UNCFG after a fixed number of cycles.
- Reset returns every state to UNCFG.

Top module: `cfg_guard_top`

## Requirements
- R1: After reset the controller is in UNCFG. All grant, deny and wipe pulses are low, start_en is low, crypto_free is high and tamper is low.
- R2: An encrypted load opens only on a frame write at address 0. An encrypted opening frame at any other address gets frm_deny and the controller stays in UNCFG (crypto_free stays high).
- R3: Within an encrypted load each granted frame must be at the address one above the previous frame. A frame at any other address gets frm_deny and wipe_pulse in the same cycle, and the controller enters CLEAR.
- R4: rb_req is denied in LOAD_ENC, in CHECK after an encrypted load, in RUN_ENC and in CLEAR. It is granted in UNCFG, LOAD_PLN, CHECK after a plain load, and RUN_PLN.
- R5: key_rd_req or key_wr_req in any state gives key_deny and wipe_pulse in the next cycle and sends the controller to CLEAR. It also sets tamper, which only reset clears.
- R6: start_en rises only in the cycle after chk_done with chk_pass high. chk_done with chk_pass low gives wipe_pulse and CLEAR, and start_en stays low.
- R7: crypto_free is low from the cycle after an encrypted load opens, through CHECK and RUN_ENC, and during CLEAR. It is high in UNCFG and in the plain states.
- R8: In RUN_ENC every frame write and command word is denied. The controller stays in RUN_ENC until wipe_cmd, a key access, or reset.
- R9: During LOAD_ENC, and in CHECK, plain command words (cmd_req) are granted, including in the same cycle as a granted frame.
- R10: wipe_cmd gives wipe_pulse and CLEAR. CLEAR lasts exactly CLR_CYCLES cycles (4 by default) and then returns to UNCFG. Frame, command and readback requests in CLEAR are denied.
- R11: A plain load grants frames at any address and in any order, and completes on a frame at address LAST_FRAME. In RUN_PLN, plain frames are granted (reconfiguration) and encrypted frames are denied.
- R12: Priority is key access, then wipe_cmd, then the per-state rules. A key access in the same cycle as a passing chk_done leaves start_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; wipes all state |
| frm_wr_req | input | 1 | Frame write request |
| frm_enc | input | 1 | Frame belongs to an encrypted load |
| frm_addr | input | AW | Frame address |
| cmd_req | input | 1 | Plain command word request |
| rb_req | input | 1 | Readback request |
| key_rd_req | input | 1 | Key memory read attempt |
| key_wr_req | input | 1 | Key memory write attempt |
| wipe_cmd | input | 1 | Full-clear command |
| chk_done | input | 1 | Integrity result valid |
| chk_pass | input | 1 | Integrity result (1 = pass) |
| frm_grant | output | 1 | Frame write accepted (pulse) |
| frm_deny | output | 1 | Frame write refused (pulse) |
| cmd_grant | output | 1 | Command word accepted (pulse) |
| cmd_deny | output | 1 | Command word refused (pulse) |
| rb_grant | output | 1 | Readback accepted (pulse) |
| rb_deny | output | 1 | Readback refused (pulse) |
| key_deny | output | 1 | Key access refused (pulse) |
| wipe_pulse | output | 1 | Clear keys and configuration (pulse) |
| start_en | output | 1 | Design allowed to run |
| crypto_free | output | 1 | Decryptor available to user logic |
| tamper | output | 1 | Sticky key-access flag |

## Verification
The sharpest collision is a key-memory access arriving in the same cycle as a passing integrity result. The bench drives key_wr_req together with chk_done and chk_pass while the controller sits in CHECK after an encrypted load. The run is judged correct when the next cycle shows key_deny, wipe_pulse and tamper with start_en still low. A second collision pairs a granted encrypted frame with a plain command word in one cycle, and both must be granted together.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

    typedef enum logic [2:0] {
        ST_UNCFG    = 3'd0,
        ST_LOAD_ENC = 3'd1,
        ST_LOAD_PLN = 3'd2,
        ST_CHECK    = 3'd3,
        ST_RUN_ENC  = 3'd4,
        ST_RUN_PLN  = 3'd5,
        ST_CLEAR    = 3'd6
    } guard_state_e;

    typedef struct packed {
        logic frm_g;
        logic frm_d;
        logic cmd_g;
        logic cmd_d;
        logic rb_g;
        logic rb_d;
        logic key_d;
        logic wipe;
    } verdict_t;

endpackage

// File: rtl/cfg_frame_seq.sv
module cfg_frame_seq #(
    parameter int AW         = 8,
    parameter int LAST_FRAME = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] addr,
    output logic          in_order,
    output logic          is_last
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(LAST_FRAME);
    localparam logic [AW-1:0] ONE       = AW'(1);

    logic [AW-1:0] want_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            want_q <= '0;
        else if (load)
            want_q <= addr + ONE;
        else if (adv)
            want_q <= want_q + ONE;
    end

    assign in_order = (addr == want_q);
    assign is_last  = (addr == LAST_ADDR);

    // R3
    seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> in_order);

endmodule

// File: rtl/cfg_clear_timer.sv
module cfg_clear_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    output logic done
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= '0;
        else if (active && !done)
            cnt_q <= cnt_q + CW'(1);
    end

    assign done = (cnt_q == LAST_CNT);

    // R10
    clear_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && done && !start) |=> !active);

endmodule

// File: rtl/cfg_guard_fsm.sv
module cfg_guard_fsm
    import cfg_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frm_wr_req,
    input  logic frm_enc,
    input  logic addr_zero,
    input  logic in_order,
    input  logic is_last,
    input  logic cmd_req,
    input  logic rb_req,
    input  logic key_rd_req,
    input  logic key_wr_req,
    input  logic wipe_cmd,
    input  logic chk_done,
    input  logic chk_pass,
    input  logic clr_done,
    output logic seq_load,
    output logic seq_adv,
    output logic clr_start,
    output logic clr_active,
    output logic frm_grant,
    output logic frm_deny,
    output logic cmd_grant,
    output logic cmd_deny,
    output logic rb_grant,
    output logic rb_deny,
    output logic key_deny,
    output logic wipe_pulse,
    output logic start_en,
    output logic crypto_free,
    output logic tamper
);
    guard_state_e st_q, st_n;
    logic         enc_q, enc_n;
    verdict_t     vd, vd_q;
    logic         key_hit, kill;

    assign key_hit = key_rd_req | key_wr_req;
    assign kill    = key_hit | wipe_cmd;

    // next-state and verdict decode
    always_comb begin
        st_n      = st_q;
        enc_n     = enc_q;
        vd        = '0;
        seq_load  = 1'b0;
        seq_adv   = 1'b0;
        clr_start = 1'b0;
        unique case (st_q)
            ST_UNCFG: begin
                vd.cmd_g = cmd_req;
                vd.rb_g  = rb_req;
                if (frm_wr_req) begin
                    if (frm_enc && !addr_zero) begin
                        vd.frm_d = 1'b1;
                    end else begin
                        vd.frm_g = 1'b1;
                        seq_load = 1'b1;
                        enc_n    = frm_enc;
                        if (is_last)
                            st_n = ST_CHECK;
                        else
                            st_n = frm_enc ? ST_LOAD_ENC : ST_LOAD_PLN;
                    end
                end
            end
            ST_LOAD_ENC: begin
                vd.cmd_g = cmd_req;
                vd.rb_d  = rb_req;
                if (frm_wr_req) begin
                    if (in_order) begin
                        vd.frm_g = 1'b1;
                        seq_adv  = 1'b1;
                        if (is_last)
                            st_n = ST_CHECK;
                    end else begin
                        vd.frm_d  = 1'b1;
                        vd.wipe   = 1'b1;
                        clr_start = 1'b1;
                        enc_n     = 1'b0;
                        st_n      = ST_CLEAR;
                    end
                end
            end
            ST_LOAD_PLN: begin
                vd.cmd_g = cmd_req;
                vd.rb_g  = rb_req;
                vd.frm_g = frm_wr_req;
                if (frm_wr_req && is_last)
                    st_n = ST_CHECK;
            end
            ST_CHECK: begin
                vd.cmd_g = cmd_req;
                vd.rb_g  = rb_req & ~enc_q;
                vd.rb_d  = rb_req & enc_q;
                vd.frm_d = frm_wr_req;
                if (chk_done) begin
                    if (chk_pass) begin
                        st_n = enc_q ? ST_RUN_ENC : ST_RUN_PLN;
                    end else begin
                        vd.wipe   = 1'b1;
                        clr_start = 1'b1;
                        enc_n     = 1'b0;
                        st_n      = ST_CLEAR;
                    end
                end
            end
            ST_RUN_ENC: begin
                vd.cmd_d = cmd_req;
                vd.rb_d  = rb_req;
                vd.frm_d = frm_wr_req;
            end
            ST_RUN_PLN: begin
                vd.cmd_g = cmd_req;
                vd.rb_g  = rb_req;
                vd.frm_g = frm_wr_req & ~frm_enc;
                vd.frm_d = frm_wr_req & frm_enc;
            end
            ST_CLEAR: begin
                vd.cmd_d = cmd_req;
                vd.rb_d  = rb_req;
                vd.frm_d = frm_wr_req;
                enc_n    = 1'b0;
                if (clr_done)
                    st_n = ST_UNCFG;
            end
            default: begin
                st_n  = ST_CLEAR;
                enc_n = 1'b0;
            end
        endcase
        // key access outranks the full-clear command, which outranks all else
        if (kill) begin
            vd.frm_g  = 1'b0;
            vd.cmd_g  = 1'b0;
            vd.rb_g   = 1'b0;
            vd.frm_d  = frm_wr_req;
            vd.cmd_d  = cmd_req;
            vd.rb_d   = rb_req;
            vd.key_d  = key_hit;
            vd.wipe   = 1'b1;
            seq_load  = 1'b0;
            seq_adv   = 1'b0;
            clr_start = 1'b1;
            enc_n     = 1'b0;
            st_n      = ST_CLEAR;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_UNCFG;
            enc_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            enc_q <= enc_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_q   <= '0;
            tamper <= 1'b0;
        end else begin
            vd_q <= vd;
            if (key_hit)
                tamper <= 1'b1;
        end
    end

    assign frm_grant   = vd_q.frm_g;
    assign frm_deny    = vd_q.frm_d;
    assign cmd_grant   = vd_q.cmd_g;
    assign cmd_deny    = vd_q.cmd_d;
    assign rb_grant    = vd_q.rb_g;
    assign rb_deny     = vd_q.rb_d;
    assign key_deny    = vd_q.key_d;
    assign wipe_pulse  = vd_q.wipe;
    assign clr_active  = (st_q == ST_CLEAR);
    assign start_en    = (st_q == ST_RUN_ENC) || (st_q == ST_RUN_PLN);
    assign crypto_free = (st_q == ST_UNCFG) || (st_q == ST_LOAD_PLN) ||
                         (st_q == ST_RUN_PLN) || ((st_q == ST_CHECK) && !enc_q);

    // R5
    key_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_rd_req || key_wr_req) |=> (key_deny && wipe_pulse && tamper));

    // R6
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_en) |-> $past(chk_done && chk_pass && !key_rd_req && !key_wr_req));

    // R10
    wipe_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_pulse |-> (!start_en && !crypto_free));

    // R8
    runenc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_en && !crypto_free && !wipe_cmd && !key_rd_req && !key_wr_req)
            |=> (start_en && !crypto_free && !frm_grant && !cmd_grant));

    // R4
    rb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rb_grant, rb_deny, frm_grant && frm_deny}));

endmodule

// File: rtl/cfg_guard_top.sv
module cfg_guard_top #(
    parameter int AW         = 8,
    parameter int LAST_FRAME = 255,
    parameter int CLR_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_wr_req,
    input  logic          frm_enc,
    input  logic [AW-1:0] frm_addr,
    input  logic          cmd_req,
    input  logic          rb_req,
    input  logic          key_rd_req,
    input  logic          key_wr_req,
    input  logic          wipe_cmd,
    input  logic          chk_done,
    input  logic          chk_pass,
    output logic          frm_grant,
    output logic          frm_deny,
    output logic          cmd_grant,
    output logic          cmd_deny,
    output logic          rb_grant,
    output logic          rb_deny,
    output logic          key_deny,
    output logic          wipe_pulse,
    output logic          start_en,
    output logic          crypto_free,
    output logic          tamper
);
    logic seq_load, seq_adv, in_order, is_last;
    logic clr_start, clr_active, clr_done;
    logic addr_zero;

    assign addr_zero = (frm_addr == '0);

    cfg_frame_seq #(.AW(AW), .LAST_FRAME(LAST_FRAME)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_load),
        .adv      (seq_adv),
        .addr     (frm_addr),
        .in_order (in_order),
        .is_last  (is_last)
    );

    cfg_clear_timer #(.CYCLES(CLR_CYCLES)) u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (clr_start),
        .active (clr_active),
        .done   (clr_done)
    );

    cfg_guard_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_wr_req  (frm_wr_req),
        .frm_enc     (frm_enc),
        .addr_zero   (addr_zero),
        .in_order    (in_order),
        .is_last     (is_last),
        .cmd_req     (cmd_req),
        .rb_req      (rb_req),
        .key_rd_req  (key_rd_req),
        .key_wr_req  (key_wr_req),
        .wipe_cmd    (wipe_cmd),
        .chk_done    (chk_done),
        .chk_pass    (chk_pass),
        .clr_done    (clr_done),
        .seq_load    (seq_load),
        .seq_adv     (seq_adv),
        .clr_start   (clr_start),
        .clr_active  (clr_active),
        .frm_grant   (frm_grant),
        .frm_deny    (frm_deny),
        .cmd_grant   (cmd_grant),
        .cmd_deny    (cmd_deny),
        .rb_grant    (rb_grant),
        .rb_deny     (rb_deny),
        .key_deny    (key_deny),
        .wipe_pulse  (wipe_pulse),
        .start_en    (start_en),
        .crypto_free (crypto_free),
        .tamper      (tamper)
    );

endmodule

// File: tb/tb_cfg_guard_top.sv
`timescale 1ns/1ps
module tb_cfg_guard_top;
    localparam int AW = 4;
    localparam int NV = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_wr_req = 0, frm_enc = 0, cmd_req = 0, rb_req = 0;
    logic key_rd_req = 0, key_wr_req = 0, wipe_cmd = 0, chk_done = 0, chk_pass = 0;
    logic [AW-1:0] frm_addr = '0;
    logic frm_grant, frm_deny, cmd_grant, cmd_deny, rb_grant, rb_deny;
    logic key_deny, wipe_pulse, start_en, crypto_free, tamper;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cfg_guard_top #(.AW(AW), .LAST_FRAME(3), .CLR_CYCLES(4)) dut (
        .clk(clk), .rst_n(rst_n), .frm_wr_req(frm_wr_req), .frm_enc(frm_enc),
        .frm_addr(frm_addr), .cmd_req(cmd_req), .rb_req(rb_req),
        .key_rd_req(key_rd_req), .key_wr_req(key_wr_req), .wipe_cmd(wipe_cmd),
        .chk_done(chk_done), .chk_pass(chk_pass), .frm_grant(frm_grant),
        .frm_deny(frm_deny), .cmd_grant(cmd_grant), .cmd_deny(cmd_deny),
        .rb_grant(rb_grant), .rb_deny(rb_deny), .key_deny(key_deny),
        .wipe_pulse(wipe_pulse), .start_en(start_en), .crypto_free(crypto_free),
        .tamper(tamper)
    );

    // stimulus: frm enc addr[3:0] cmd rb keyrd keywr wipe cdone cpass
    // expect:   fg fd cg cd rg rd kd wp start free tamper
    localparam logic [23:0] VEC [NV] = '{
        24'b0_0_0000_0_0_0_0_0_0_0__0_0_0_0_0_0_0_0_0_1_0, // R1 idle
        24'b0_0_0000_0_1_0_0_0_0_0__0_0_0_0_1_0_0_0_0_1_0, // R4 rb in UNCFG
        24'b1_1_0010_0_0_0_0_0_0_0__0_1_0_0_0_0_0_0_0_1_0, // R2 enc opens at 2
        24'b1_1_0000_0_0_0_0_0_0_0__1_0_0_0_0_0_0_0_0_0_0, // R2 R7 enc opens at 0
        24'b0_0_0000_1_0_0_0_0_0_0__0_0_1_0_0_0_0_0_0_0_0, // R9 cmd in load
        24'b0_0_0000_0_1_0_0_0_0_0__0_0_0_0_0_1_0_0_0_0_0, // R4 rb denied
        24'b1_1_0001_0_0_0_0_0_0_0__1_0_0_0_0_0_0_0_0_0_0, // R3 frame 1
        24'b1_1_0010_1_0_0_0_0_0_0__1_0_1_0_0_0_0_0_0_0_0, // R9 frame 2 + cmd
        24'b1_1_0011_0_0_0_0_0_0_0__1_0_0_0_0_0_0_0_0_0_0, // R3 last frame
        24'b0_0_0000_0_1_0_0_0_0_0__0_0_0_0_0_1_0_0_0_0_0, // R4 rb in CHECK enc
        24'b0_0_0000_0_0_0_0_0_1_1__0_0_0_0_0_0_0_0_1_0_0, // R6 pass
        24'b1_1_0000_0_0_0_0_0_0_0__0_1_0_0_0_0_0_0_1_0_0, // R8 frame denied
        24'b0_0_0000_1_0_0_0_0_0_0__0_0_0_1_0_0_0_0_1_0_0, // R8 cmd denied
        24'b0_0_0000_0_1_0_0_0_0_0__0_0_0_0_0_1_0_0_1_0_0, // R4 rb denied
        24'b0_0_0000_0_0_0_0_1_0_0__0_0_0_0_0_0_0_1_0_0_0, // R10 wipe
        24'b0_0_0000_0_1_0_0_0_0_0__0_0_0_0_0_1_0_0_0_0_0, // R10 rb in CLEAR
        24'b1_0_0000_0_0_0_0_0_0_0__0_1_0_0_0_0_0_0_0_0_0, // R10 frame in CLEAR
        24'b0_0_0000_0_0_0_0_0_0_0__0_0_0_0_0_0_0_0_0_0_0, // R10 still CLEAR
        24'b0_0_0000_0_0_0_0_0_0_0__0_0_0_0_0_0_0_0_0_1_0, // R10 back to UNCFG
        24'b1_0_0010_0_0_0_0_0_0_0__1_0_0_0_0_0_0_0_0_1_0, // R11 plain at 2
        24'b1_0_0000_0_0_0_0_0_0_0__1_0_0_0_0_0_0_0_0_1_0, // R11 plain at 0
        24'b0_0_0000_0_1_0_0_0_0_0__0_0_0_0_1_0_0_0_0_1_0, // R4 rb in plain
        24'b1_0_0011_0_0_0_0_0_0_0__1_0_0_0_0_0_0_0_0_1_0, // R11 plain last
        24'b0_0_0000_0_0_0_0_0_1_0__0_0_0_0_0_0_0_1_0_0_0, // R6 fail
        24'b0_0_0000_0_0_0_0_0_0_0__0_0_0_0_0_0_0_0_0_0_0,
        24'b0_0_0000_0_0_0_0_0_0_0__0_0_0_0_0_0_0_0_0_0_0,
        24'b0_0_0000_0_0_0_0_0_0_0__0_0_0_0_0_0_0_0_0_0_0,
        24'b0_0_0000_0_0_0_0_0_0_0__0_0_0_0_0_0_0_0_0_1_0  // R10 UNCFG
    };

    function automatic logic [10:0] obs();
        return {frm_grant, frm_deny, cmd_grant, cmd_deny, rb_grant, rb_deny,
                key_deny, wipe_pulse, start_en, crypto_free, tamper};
    endfunction

    task automatic check(input string tag, input logic [10:0] exp_v);
        logic [10:0] got;
        got = obs();
        n_chk++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp_v);
        end
    endtask

    task automatic run(input logic [12:0] s, input logic [10:0] e, input string tag);
        {frm_wr_req, frm_enc, frm_addr, cmd_req, rb_req, key_rd_req,
         key_wr_req, wipe_cmd, chk_done, chk_pass} = s;
        @(posedge clk);
        @(negedge clk);
        {frm_wr_req, frm_enc, frm_addr, cmd_req, rb_req, key_rd_req,
         key_wr_req, wipe_cmd, chk_done, chk_pass} = '0;
        check(tag, e);
    endtask

    task automatic drain(input logic t, input string tag);
        for (int k = 0; k < 3; k++)
            run(13'b0, {10'b0, t}, tag);
        run(13'b0, {9'b0, 1'b1, t}, tag);
    endtask

    task automatic enc_full(input logic t, input string tag);
        for (int a = 0; a < 4; a++)
            run({2'b11, 4'(a), 7'b0}, {1'b1, 9'b0, t}, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 11'b0_0_0_0_0_0_0_0_0_1_0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++)
            run(VEC[i][23:11], VEC[i][10:0], $sformatf("table vector %0d", i));

        // R11 plain load completes on last frame, reconfiguration while running
        run(13'b1_0_0011_0_0_0_0_0_0_0, 11'b1_0_0_0_0_0_0_0_0_1_0, "R11 plain single frame");
        run(13'b0_0_0000_0_0_0_0_0_1_1, 11'b0_0_0_0_0_0_0_0_1_1_0, "R6 plain pass");
        run(13'b1_0_0001_0_0_0_0_0_0_0, 11'b1_0_0_0_0_0_0_0_1_1_0, "R11 reconfig frame");
        run(13'b0_0_0000_0_1_0_0_0_0_0, 11'b0_0_0_0_1_0_0_0_1_1_0, "R4 rb in RUN_PLN");
        run(13'b1_1_0000_0_0_0_0_0_0_0, 11'b0_1_0_0_0_0_0_0_1_1_0, "R11 enc frame in RUN_PLN");
        run(13'b0_0_0000_0_0_0_0_1_0_0, 11'b0_0_0_0_0_0_0_1_0_0_0, "R10 wipe from RUN_PLN");
        drain(1'b0, "R10 clear length");

        // R3 out-of-order encrypted frame aborts
        run(13'b1_1_0000_0_0_0_0_0_0_0, 11'b1_0_0_0_0_0_0_0_0_0_0, "R3 open");
        run(13'b1_1_0010_0_0_0_0_0_0_0, 11'b0_1_0_0_0_0_0_1_0_0_0, "R3 skip aborts");
        drain(1'b0, "R3 abort clear");

        // R12 key access collides with a passing integrity result
        enc_full(1'b0, "R7 enc load");
        run(13'b0_0_0000_0_0_0_1_0_1_1, 11'b0_0_0_0_0_0_1_1_0_0_1, "R12 key beats pass");
        drain(1'b1, "R5 tamper sticky");
        run(13'b0_0_0000_0_0_0_0_1_0_0, 11'b0_0_0_0_0_0_0_1_0_0_1, "R5 wipe keeps tamper");
        drain(1'b1, "R5 tamper after wipe");
        run(13'b0_0_0000_0_0_1_0_0_0_0, 11'b0_0_0_0_0_0_1_1_0_0_1, "R5 key read in UNCFG");
        drain(1'b1, "R5 clear after key read");

        // R8 encrypted run holds until reset
        enc_full(1'b1, "R8 enc load");
        run(13'b0_0_0000_0_0_0_0_0_1_1, 11'b0_0_0_0_0_0_0_0_1_0_1, "R8 running");
        run(13'b0, 11'b0_0_0_0_0_0_0_0_1_0_1, "R8 holds");
        run(13'b0, 11'b0_0_0_0_0_0_0_0_1_0_1, "R8 still holds");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 R8 reset wipes", 11'b0_0_0_0_0_0_0_0_0_1_0);
        rst_n = 1'b1;
        run(13'b1_1_0001_0_0_0_0_0_0_0, 11'b0_1_0_0_0_0_0_0_0_1_0, "R2 enc opens at 1");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule